// File: doc/BRIEF.md
# Interleaved Chroma 4x4 Reconstruction Unit

This block rebuilds one 4x4 block of a single chroma component whose picture rows store the two chroma components byte-interleaved. For each block it takes sixteen quantized coefficients with their per-position scale and weight factors, a shift amount (the quantizer step divided by six), a separately computed DC value, four eight-byte prediction rows and the four eight-byte output rows that already exist in memory. It dequantizes the coefficients and replaces position 0 with the supplied DC value. It then runs a two-pass 4-point integer inverse transform, rounds the result, adds the prediction samples of its own component and clamps each pixel to eight bits. The reconstructed pixels are written into the byte lanes of this component in the old rows, and the bytes of the other component pass through unchanged.

A block is accepted in one cycle when `in_ready` is high. One cycle later the result rows are latched. The four merged rows then leave the block on four consecutive cycles, top row first. A parameter chooses whether the component sits in the even byte lanes (the default) or the odd ones.

Top module: `icr_chroma_recon`

## Requirements
- R1: Each coefficient at positions 1..15 is dequantized as follows. Take the low 16 bits of scale*weight as a signed value w. Form the signed 32-bit product coef*w and shift it left by `qp_div6` with 32-bit wraparound. Add 8, shift right arithmetically by 4 and saturate to the signed 16-bit range.
- R2: The transform input at position 0 is always `dc_in`, so coefficient, scale and weight lane 0 have no effect on the output.
- R3: Each row of four values and then each column of the row results passes through the butterfly a=x0+x2, b=x0-x2, c=(x1>>>1)-x3, e=x1+(x3>>>1), giving outputs a+e, b+c, b-c, a-e in that order. The arithmetic wraps at 16 bits. Position i of a block is row i/4, column i%4, held at bits [16i+15:16i] of the coefficient, scale and weight ports.
- R4: Row r of the prediction and old-output ports sits at bits [64r+63:64r], with byte k at bits [8k+7:8k]. With LANE_SEL=0, pixel j of row r is predicted by byte 2j.
- R5: Each transformed value v becomes (v+32)>>>6. The prediction byte is added with 16-bit wraparound and the sum is clamped to 0..255.
- R6: In every output row, the bytes of the other component equal the same bytes of the old output row.
- R7: `out_valid` rises on the second clock edge after an accepting edge. It stays high for four cycles with `out_row_idx` counting 0,1,2,3, and drops after row 3.
- R8: `in_ready` is low from the accepting edge until the edge that retires row 3. `in_valid` asserted in that window is ignored and starts no block.
- R9: With LANE_SEL=1, the component uses odd bytes 2j+1 for prediction and output, and the even bytes are preserved instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Block offered on the inputs |
| in_ready | output | 1 | Block can be accepted this cycle |
| coef_in | input | 256 | Sixteen signed 16-bit quantized coefficients |
| scale_in | input | 256 | Sixteen unsigned 16-bit dequantization scales |
| weight_in | input | 256 | Sixteen unsigned 16-bit weights |
| qp_div6 | input | 4 | Left shift applied after the products |
| dc_in | input | 16 | Signed DC value that replaces position 0 |
| pred_rows | input | 256 | Four interleaved eight-byte prediction rows |
| prev_rows | input | 256 | Four eight-byte rows currently in the output buffer |
| out_valid | output | 1 | A merged row is on `out_row` |
| out_row | output | 64 | Merged interleaved output row |
| out_row_idx | output | 2 | Row number 0..3 of `out_row` |

## Verification
An all-zero block and a block with only a large lane-0 coefficient both must return the prediction bytes with the old bytes interleaved. Either case separates the lane selection and DC replacement from the transform. Blocks with a single AC coefficient at each of the fifteen positions expose any swapped row or column, butterfly sign or half-shift. Random blocks over several shift amounts test the dequantization rounding. Extreme inputs drive the 16-bit saturation, the negative interpretation of the weight product and both pixel clamps. Input offered while busy, and a second instance with odd lanes fed the same stimulus, cover the handshake and the lane parameter.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int BLK_N  = 4;
  localparam int COEF_W = 16;
  localparam int PIX_W  = 8;
  localparam int QP_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFORM = 2'd1,
    ST_EMIT  = 2'd2
  } icr_state_e;
endpackage

// File: rtl/icr_dequant.sv
module icr_dequant #(
  parameter int N_COEF = 16,
  parameter int CW     = 16,
  parameter int QW     = 4
) (
  input  logic [N_COEF*CW-1:0] coef_i,
  input  logic [N_COEF*CW-1:0] scale_i,
  input  logic [N_COEF*CW-1:0] weight_i,
  input  logic [QW-1:0]        qp_i,
  input  logic [CW-1:0]        dc_i,
  output logic [N_COEF*CW-1:0] deq_o
);
  localparam int PW     = 2*CW;
  localparam int RW     = PW + 1;
  localparam int RND_SH = 4;
  localparam logic signed [RW-1:0] RND_ADD = RW'(64'sd1 <<< (RND_SH-1));
  localparam logic signed [RW-1:0] SAT_HI  = RW'((64'sd1 <<< (CW-1)) - 64'sd1);
  localparam logic signed [RW-1:0] SAT_LO  = -SAT_HI - RW'(1);

  always_comb begin
    deq_o = '0;
    deq_o[CW-1:0] = dc_i;  // position 0 always taken from the DC input
    for (int i = 1; i < N_COEF; i++) begin
      logic [CW-1:0]          wq;
      logic signed [CW-1:0]   cf;
      logic signed [PW-1:0]   prod;
      logic signed [PW-1:0]   shl;
      logic signed [RW-1:0]   rsh;
      wq   = scale_i[i*CW +: CW] * weight_i[i*CW +: CW];
      cf   = coef_i[i*CW +: CW];
      prod = PW'(cf) * PW'($signed(wq));
      shl  = prod <<< qp_i;
      rsh  = (RW'(shl) + RND_ADD) >>> RND_SH;
      if (rsh > SAT_HI)      deq_o[i*CW +: CW] = CW'(SAT_HI);
      else if (rsh < SAT_LO) deq_o[i*CW +: CW] = CW'(SAT_LO);
      else                   deq_o[i*CW +: CW] = CW'(rsh);
    end
  end
endmodule

// File: rtl/icr_butterfly4.sv
module icr_butterfly4 #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] x1,
  input  logic signed [W-1:0] x2,
  input  logic signed [W-1:0] x3,
  output logic signed [W-1:0] y0,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y2,
  output logic signed [W-1:0] y3
);
  logic signed [W-1:0] sum_even, dif_even, odd_lo, odd_hi;

  always_comb begin
    sum_even = x0 + x2;
    dif_even = x0 - x2;
    odd_lo   = (x1 >>> 1) - x3;
    odd_hi   = x1 + (x3 >>> 1);
    y0 = sum_even + odd_hi;
    y1 = dif_even + odd_lo;
    y2 = dif_even - odd_lo;
    y3 = sum_even - odd_hi;
  end
endmodule

// File: rtl/icr_xform2d.sv
module icr_xform2d #(
  parameter int N  = 4,
  parameter int CW = 16
) (
  input  logic [N*N*CW-1:0] blk_i,
  output logic [N*N*CW-1:0] res_o
);
  logic [N*N*CW-1:0] hpass;

  // horizontal pass: one butterfly per row
  for (genvar r = 0; r < N; r++) begin : g_row
    icr_butterfly4 #(.W(CW)) u_bf (
      .x0(blk_i[(r*N+0)*CW +: CW]), .x1(blk_i[(r*N+1)*CW +: CW]),
      .x2(blk_i[(r*N+2)*CW +: CW]), .x3(blk_i[(r*N+3)*CW +: CW]),
      .y0(hpass[(r*N+0)*CW +: CW]), .y1(hpass[(r*N+1)*CW +: CW]),
      .y2(hpass[(r*N+2)*CW +: CW]), .y3(hpass[(r*N+3)*CW +: CW])
    );
  end

  // vertical pass: one butterfly per column of the row results
  for (genvar c = 0; c < N; c++) begin : g_col
    icr_butterfly4 #(.W(CW)) u_bf (
      .x0(hpass[(0*N+c)*CW +: CW]), .x1(hpass[(1*N+c)*CW +: CW]),
      .x2(hpass[(2*N+c)*CW +: CW]), .x3(hpass[(3*N+c)*CW +: CW]),
      .y0(res_o[(0*N+c)*CW +: CW]), .y1(res_o[(1*N+c)*CW +: CW]),
      .y2(res_o[(2*N+c)*CW +: CW]), .y3(res_o[(3*N+c)*CW +: CW])
    );
  end
endmodule

// File: rtl/icr_merge.sv
module icr_merge #(
  parameter int N    = 4,
  parameter int CW   = 16,
  parameter int PW   = 8,
  parameter int LANE = 0
) (
  input  logic [N*N*CW-1:0]     res_i,
  input  logic [N*2*N*PW-1:0]   pred_i,
  input  logic [N*2*N*PW-1:0]   prev_i,
  output logic [N*2*N*PW-1:0]   rows_o
);
  localparam int ROW_W   = 2*N*PW;
  localparam int RSH     = 6;
  localparam int PIX_MAX = (1 << PW) - 1;
  localparam logic signed [CW:0] RND_ADD = (CW+1)'(1 << (RSH-1));

  always_comb begin
    rows_o = prev_i;  // the other component's bytes pass through
    for (int r = 0; r < N; r++) begin
      for (int j = 0; j < N; j++) begin
        logic signed [CW-1:0] rv;
        logic signed [CW:0]   rr;
        logic [PW-1:0]        pix;
        logic signed [CW-1:0] sum;
        rv  = res_i[(r*N+j)*CW +: CW];
        rr  = ((CW+1)'(rv) + RND_ADD) >>> RSH;
        pix = pred_i[r*ROW_W + (2*j+LANE)*PW +: PW];
        sum = CW'(rr) + CW'(pix);
        if (sum < 0)
          rows_o[r*ROW_W + (2*j+LANE)*PW +: PW] = '0;
        else if (sum > PIX_MAX)
          rows_o[r*ROW_W + (2*j+LANE)*PW +: PW] = '1;
        else
          rows_o[r*ROW_W + (2*j+LANE)*PW +: PW] = PW'(sum);
      end
    end
  end
endmodule

// File: rtl/icr_chroma_recon.sv
module icr_chroma_recon #(
  parameter int LANE_SEL = 0,
  parameter int BLK_N    = icr_pkg::BLK_N,
  parameter int COEF_W   = icr_pkg::COEF_W,
  parameter int PIX_W    = icr_pkg::PIX_W,
  parameter int QP_W     = icr_pkg::QP_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [BLK_N*BLK_N*COEF_W-1:0]    coef_in,
  input  logic [BLK_N*BLK_N*COEF_W-1:0]    scale_in,
  input  logic [BLK_N*BLK_N*COEF_W-1:0]    weight_in,
  input  logic [QP_W-1:0]                  qp_div6,
  input  logic [COEF_W-1:0]                dc_in,
  input  logic [BLK_N*2*BLK_N*PIX_W-1:0]   pred_rows,
  input  logic [BLK_N*2*BLK_N*PIX_W-1:0]   prev_rows,
  output logic                             out_valid,
  output logic [2*BLK_N*PIX_W-1:0]         out_row,
  output logic [$clog2(BLK_N)-1:0]         out_row_idx
);
  import icr_pkg::*;

  localparam int NCOEF  = BLK_N*BLK_N;
  localparam int BLK_W  = NCOEF*COEF_W;
  localparam int ROW_W  = 2*BLK_N*PIX_W;
  localparam int FRM_W  = BLK_N*ROW_W;
  localparam int IDX_W  = $clog2(BLK_N);
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(BLK_N-1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  icr_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               take_in, take_rows;
  logic [BLK_W-1:0]   deq_w, deq_q, res_w;
  logic [FRM_W-1:0]   pred_q, prev_q, rows_w, rows_q;

  icr_dequant #(.N_COEF(NCOEF), .CW(COEF_W), .QW(QP_W)) u_deq (
    .coef_i(coef_in), .scale_i(scale_in), .weight_i(weight_in),
    .qp_i(qp_div6), .dc_i(dc_in), .deq_o(deq_w)
  );

  icr_xform2d #(.N(BLK_N), .CW(COEF_W)) u_xf (
    .blk_i(deq_q), .res_o(res_w)
  );

  icr_merge #(.N(BLK_N), .CW(COEF_W), .PW(PIX_W), .LANE(LANE_SEL)) u_mrg (
    .res_i(res_w), .pred_i(pred_q), .prev_i(prev_q), .rows_o(rows_w)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    take_in   = 1'b0;
    take_rows = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          take_in = 1'b1;
          state_d = ST_XFORM;
        end
      end
      ST_XFORM: begin
        take_rows = 1'b1;
        idx_d     = '0;
        state_d   = ST_EMIT;
      end
      ST_EMIT: begin
        if (idx_q == LAST_ROW) state_d = ST_IDLE;
        else                   idx_d   = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (take_in) begin
      deq_q  <= deq_w;
      pred_q <= pred_rows;
      prev_q <= prev_rows;
    end
    if (take_rows) rows_q <= rows_w;
  end

  assign in_ready    = (state_q == ST_IDLE);
  assign out_valid   = (state_q == ST_EMIT);
  assign out_row     = rows_q[idx_q*ROW_W +: ROW_W];
  assign out_row_idx = idx_q;

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  first_row_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_XFORM) |=> (out_valid && out_row_idx == '0));

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_row_idx != LAST_ROW) |=>
      (out_valid && out_row_idx == IDX_W'($past(out_row_idx) + 1'b1)));

  // R8
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_row_idx == LAST_ROW) |=> (in_ready && !out_valid));

  // R7
  no_emit_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |-> !out_valid);
endmodule

// File: tb/tb_icr_chroma_recon.sv
module tb_icr_chroma_recon;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] coef_in = '0, scale_in = '0, weight_in = '0;
  logic [3:0]   qp_div6 = '0;
  logic [15:0]  dc_in = '0;
  logic [255:0] pred_rows = '0, prev_rows = '0;
  logic         rdy_e, val_e, rdy_o, val_o;
  logic [63:0]  row_e, row_o;
  logic [1:0]   idx_e, idx_o;

  int n_checks = 0;
  int n_errors = 0;
  bit running = 1'b0;

  int coef[16], scl[16], wgt[16];
  int qp, dc;
  logic [7:0] pred[4][8], prv[4][8];
  logic [63:0] exp_rows[2][4];

  logic [65:0] q_e[$], q_o[$];
  string       t_e[$], t_o[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  icr_chroma_recon dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_e),
    .coef_in(coef_in), .scale_in(scale_in), .weight_in(weight_in),
    .qp_div6(qp_div6), .dc_in(dc_in), .pred_rows(pred_rows), .prev_rows(prev_rows),
    .out_valid(val_e), .out_row(row_e), .out_row_idx(idx_e)
  );

  icr_chroma_recon #(.LANE_SEL(1)) dut_odd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_o),
    .coef_in(coef_in), .scale_in(scale_in), .weight_in(weight_in),
    .qp_div6(qp_div6), .dc_in(dc_in), .pred_rows(pred_rows), .prev_rows(prev_rows),
    .out_valid(val_o), .out_row(row_o), .out_row_idx(idx_o)
  );

  function automatic int wrap16(longint v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  // R1 reference
  function automatic int dq(int c, int s, int w, int q);
    int x, sh;
    longint p, r;
    x  = wrap16(longint'(s) * longint'(w));
    p  = longint'(c) * longint'(x);
    sh = int'(p <<< q);
    r  = (longint'(sh) + 8) >>> 4;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // R3 reference butterfly
  function automatic void bf(input int x0, x1, x2, x3, output int y0, y1, y2, y3);
    int a, b, c, e;
    a = wrap16(x0 + x2);
    b = wrap16(x0 - x2);
    c = wrap16((x1 >>> 1) - x3);
    e = wrap16(x1 + (x3 >>> 1));
    y0 = wrap16(a + e);
    y1 = wrap16(b + c);
    y2 = wrap16(b - c);
    y3 = wrap16(a - e);
  endfunction

  function automatic void model();
    int d[16], h[16], v[16];
    for (int i = 0; i < 16; i++)
      d[i] = (i == 0) ? wrap16(dc) : dq(coef[i], scl[i], wgt[i], qp);
    for (int r = 0; r < 4; r++)
      bf(d[4*r], d[4*r+1], d[4*r+2], d[4*r+3], h[4*r], h[4*r+1], h[4*r+2], h[4*r+3]);
    for (int c = 0; c < 4; c++)
      bf(h[c], h[4+c], h[8+c], h[12+c], v[c], v[4+c], v[8+c], v[12+c]);
    for (int ln = 0; ln < 2; ln++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 8; k++) begin
          int s;
          if ((k % 2) == ln) begin
            s = wrap16(((v[4*r + k/2] + 32) >>> 6) + int'(pred[r][k]));
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            exp_rows[ln][r][8*k +: 8] = 8'(s);
          end else begin
            exp_rows[ln][r][8*k +: 8] = prv[r][k];
          end
        end
  endfunction

  task automatic pack();
    for (int i = 0; i < 16; i++) begin
      coef_in[16*i +: 16]   = 16'(coef[i]);
      scale_in[16*i +: 16]  = 16'(scl[i]);
      weight_in[16*i +: 16] = 16'(wgt[i]);
    end
    qp_div6 = 4'(qp);
    dc_in   = 16'(dc);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++) begin
        pred_rows[64*r + 8*k +: 8] = pred[r][k];
        prev_rows[64*r + 8*k +: 8] = prv[r][k];
      end
  endtask

  task automatic push(string tag);
    model();
    for (int r = 0; r < 4; r++) begin
      q_e.push_back({2'(r), exp_rows[0][r]});
      q_o.push_back({2'(r), exp_rows[1][r]});
      t_e.push_back(tag);
      t_o.push_back({tag, "/R9"});
    end
  endtask

  task automatic send(string tag);
    while (!rdy_e) @(negedge clk);
    push(tag);
    pack();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_block();
    for (int i = 0; i < 16; i++) begin
      coef[i] = 0; scl[i] = 16; wgt[i] = 16;
    end
    qp = 0; dc = 0;
  endtask

  task automatic rand_pixels();
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++) begin
        pred[r][k] = 8'($urandom);
        prv[r][k]  = 8'($urandom);
      end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running && val_e) begin
      if (q_e.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R8: unexpected row %0d got %h expected none", idx_e, row_e);
      end else begin
        logic [65:0] e;
        string tg;
        e = q_e.pop_front(); tg = t_e.pop_front();
        check(tg, {62'(idx_e), row_e}, {62'(e[65:64]), e[63:0]});
      end
    end
    if (running && val_o) begin
      if (q_o.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R9: unexpected row %0d got %h expected none", idx_o, row_o);
      end else begin
        logic [65:0] e;
        string tg;
        e = q_o.pop_front(); tg = t_o.pop_front();
        check(tg, {62'(idx_o), row_o}, {62'(e[65:64]), e[63:0]});
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL R7: watchdog expired got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    running = 1'b1;
    // reset state (R7, R8)
    check("R8 reset ready", 64'(rdy_e), 64'd1);
    check("R7 reset valid", 64'(val_e), 64'd0);

    // R4 R6: zero block returns prediction merged with old bytes
    clear_block(); rand_pixels();
    send("R4 R6 zero block");

    // R2: lane-0 coefficient ignored, DC replaces it
    clear_block(); coef[0] = 1000; scl[0] = 200; wgt[0] = 90; rand_pixels();
    send("R2 lane0 ignored");
    clear_block(); dc = 640; rand_pixels();
    send("R2 dc only");
    clear_block(); dc = -1500; coef[0] = -7; rand_pixels();
    send("R2 negative dc");

    // R3: one AC coefficient at each position
    for (int p = 1; p < 16; p++) begin
      clear_block(); qp = 2; coef[p] = (p % 2) ? 37 : -53; rand_pixels();
      send("R3 single coef");
    end

    // R1: random blocks over shift amounts
    for (int n = 0; n < 24; n++) begin
      clear_block();
      for (int i = 0; i < 16; i++) begin
        coef[i] = int'($urandom_range(400)) - 200;
        scl[i]  = int'($urandom_range(29, 10));
        wgt[i]  = int'($urandom_range(24, 8));
      end
      qp = n % 6; dc = int'($urandom_range(2000)) - 1000;
      rand_pixels();
      send("R1 random block");
    end

    // R1: saturation and negative weight product
    clear_block();
    for (int i = 1; i < 16; i++) begin coef[i] = 32767; scl[i] = 255; wgt[i] = 128; end
    qp = 1; rand_pixels();
    send("R1 saturate high");
    clear_block();
    for (int i = 1; i < 16; i++) begin coef[i] = (i < 8) ? 3 : -2; scl[i] = 300; wgt[i] = 200; end
    qp = 3; rand_pixels();
    send("R1 signed weight product");

    // R5: clamp at both ends
    clear_block(); dc = 3000; rand_pixels();
    for (int r = 0; r < 4; r++) for (int k = 0; k < 8; k++) pred[r][k] = 8'd250;
    send("R5 clamp high");
    clear_block(); dc = -3000; rand_pixels();
    for (int r = 0; r < 4; r++) for (int k = 0; k < 8; k++) pred[r][k] = 8'd5;
    send("R5 clamp low");

    // R7 R8: latency and input ignored while busy
    while (!rdy_e) @(negedge clk);
    clear_block(); dc = 200; rand_pixels();
    push("R7 latency block");
    pack();
    in_valid = 1'b1;
    @(negedge clk);
    check("R8 busy after accept", 64'(rdy_e), 64'd0);
    check("R7 no row before second edge", 64'(val_e), 64'd0);
    clear_block(); dc = -900; rand_pixels(); pack();  // offered while busy
    @(negedge clk);
    check("R7 first row valid", 64'(val_e), 64'd1);
    check("R7 first row index", 64'(idx_e), 64'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8 still busy", 64'(rdy_e), 64'd0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 ready after last row", 64'(rdy_e), 64'd1);
    check("R7 valid drops", 64'(val_e), 64'd0);
    @(negedge clk);
    check("R8 busy input not taken", 64'(val_e), 64'd0);
    check("R8 busy input not taken odd", 64'(val_o), 64'd0);

    repeat (10) @(negedge clk);
    check("R7 all rows delivered", 64'(q_e.size() + q_o.size()), 64'd0);
    summary();
    $finish;
  end
endmodule